// File: doc/BRIEF.md
# Duplicated Integer Register File with Rename Pool

This block holds the physical integer registers of an out-of-order core: 48 entries, of which 32 back the architectural registers at any moment and 16 form a pool for renaming. The storage is kept twice. One copy serves the six operand reads of three integer execution ports. The other copy serves the four operand reads of two load/store ports. Each of the five result buses writes the same entry of both copies on the same clock edge, so the copies never differ and no extra cycle is spent keeping them equal.

Around the storage sit a speculative rename map, a committed map and a free pool kept as a bitmap. Up to four destinations are renamed per cycle. Each one gets the lowest-numbered free physical register, together with the mapping it replaces. Up to four results commit per cycle, in program order. Each commit returns the previously committed register of its architectural destination to the pool. A flush rebuilds the speculative map from the committed map in a single cycle and refills the pool with every register that the committed map does not hold.

Top module: `dup_regfile`

## Requirements
- R1: While reset is high, and after it falls, every one of the 48 entries reads zero on every port. Architectural register a maps to physical register a, and the free pool holds exactly physical registers 32 to 47.
- R2: A write lands in both copies at the next rising edge and stays there until it is overwritten. An execution read port and a load/store read port that address the same entry return the same value. In every flat port vector, port or lane k occupies bits [k*W +: W], where W is the field width: 6 bits for a physical index, 5 bits for an architectural index, 64 bits for data.
- R3: A read of an entry that is being written in the same cycle returns the new data, on both copies.
- R4: When several write ports target the same entry in one cycle, the highest-numbered port's data is the value read in that cycle and the value stored.
- R5: ren_ok is high exactly when the free count is at least the number of set ren_vld bits. When ren_ok is high and flush is low, the valid lanes, taken from lane 0 upward, receive the lowest-numbered free physical registers on ren_preg (combinationally) and these leave the pool. When ren_ok is low, nothing is allocated.
- R6: ren_prev of a lane is the current speculative mapping of its architectural register. If an earlier valid lane of the same group names the same register, ren_prev is that lane's new physical register instead. Granted renames update the speculative map at the next edge.
- R7: Valid commit lanes are applied in lane order to the committed map. The physical register each one displaces is free from the next cycle on, including when two lanes of one group commit the same architectural register.
- R8: From the cycle after flush is high, the speculative map equals the committed map, including commits made in the flush cycle. The free pool then holds every register outside the committed map. Renames requested in the flush cycle change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_vld | input | 5 | Result bus valid, one bit per bus |
| wr_idx | input | 30 | Physical index per result bus |
| wr_data | input | 320 | Data per result bus |
| ex_raddr | input | 36 | Read indices of the six execution-side ports |
| ex_rdata | output | 384 | Read data of the execution-side copy |
| ls_raddr | input | 24 | Read indices of the four load/store-side ports |
| ls_rdata | output | 256 | Read data of the load/store-side copy |
| ren_vld | input | 4 | Rename request per lane |
| ren_areg | input | 20 | Architectural destination per rename lane |
| ren_ok | output | 1 | Enough free registers for all requested lanes |
| ren_preg | output | 24 | Allocated physical register per lane |
| ren_prev | output | 24 | Mapping replaced per lane |
| cmt_vld | input | 4 | Commit valid per lane |
| cmt_areg | input | 20 | Architectural destination per commit lane |
| cmt_preg | input | 24 | Physical register being committed per lane |
| flush | input | 1 | Restore speculative state from the committed state |

## Verification
The assertions take the rename and commit stream to be legal. Commits follow rename order and name only physical registers handed out in an earlier cycle, never the one being allocated in the same cycle. As a result the committed map always stays a permutation of 32 distinct registers, and a freshly allocated register cannot reappear as free one cycle later. The stimulus keeps a queue of granted renames and draws every commit from its head, drops the queue on flush, and issues read and write indices only below 48.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

    localparam int XLEN     = 64;
    localparam int ARCH_N   = 32;
    localparam int REN_N    = 16;
    localparam int PHYS_N   = ARCH_N + REN_N;
    localparam int PW       = $clog2(PHYS_N);
    localparam int AW       = $clog2(ARCH_N);
    localparam int WR_PORTS = 5;
    localparam int EX_RD    = 6;
    localparam int LS_RD    = 4;
    localparam int LANES    = 4;

    typedef logic [PW-1:0]     preg_t;
    typedef logic [AW-1:0]     areg_t;
    typedef logic [XLEN-1:0]   word_t;
    typedef logic [PHYS_N-1:0] pmask_t;

    typedef struct packed {
        logic  vld;
        preg_t idx;
        word_t data;
    } wr_req_t;

    typedef struct packed {
        logic  vld;
        areg_t areg;
    } ren_req_t;

    typedef struct packed {
        logic  vld;
        areg_t areg;
        preg_t preg;
    } cmt_req_t;

    function automatic preg_t lowest_set(input pmask_t v);
        preg_t r;
        r = '0;
        for (int k = PHYS_N - 1; k >= 0; k--) begin
            if (v[k]) r = preg_t'(k);
        end
        return r;
    endfunction

    function automatic int count_set(input pmask_t v);
        int c;
        c = 0;
        for (int k = 0; k < PHYS_N; k++) c += int'(v[k]);
        return c;
    endfunction

    function automatic pmask_t pool_at_reset();
        pmask_t v;
        for (int k = 0; k < PHYS_N; k++) v[k] = (k >= ARCH_N);
        return v;
    endfunction

endpackage

// File: rtl/rfd_bank.sv
module rfd_bank
    import rfd_pkg::*;
#(
    parameter int NR = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr    [WR_PORTS],
    input  preg_t   raddr [NR],
    output word_t   rdata [NR]
);

    word_t mem [PHYS_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < PHYS_N; e++) mem[e] <= '0;
        end else begin
            for (int p = 0; p < WR_PORTS; p++) begin
                if (wr[p].vld) mem[wr[p].idx] <= wr[p].data;
            end
        end
    end

    always_comb begin
        for (int r = 0; r < NR; r++) begin
            rdata[r] = mem[raddr[r]];
            for (int p = 0; p < WR_PORTS; p++) begin
                if (wr[p].vld && (wr[p].idx == raddr[r])) rdata[r] = wr[p].data;
            end
        end
    end

endmodule

// File: rtl/rfd_freelist.sv
module rfd_freelist
    import rfd_pkg::*;
#(
    parameter int L = LANES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         grant,
    input  logic [L-1:0] req,
    input  pmask_t       rel_mask,
    input  pmask_t       cmt_used_nxt,
    output logic         ok,
    output preg_t        pick [L]
);

    pmask_t free_q;
    pmask_t left;
    pmask_t alloc_mask;
    int     need;

    always_comb begin
        need = 0;
        for (int i = 0; i < L; i++) need += int'(req[i]);
        ok = (count_set(free_q) >= need);
    end

    always_comb begin
        left = free_q;
        for (int i = 0; i < L; i++) begin
            pick[i] = '0;
            if (req[i]) begin
                pick[i] = lowest_set(left);
                left[pick[i]] = 1'b0;
            end
        end
        alloc_mask = free_q & ~left;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= pool_at_reset();
        end else if (flush) begin
            free_q <= ~cmt_used_nxt;
        end else if (grant) begin
            free_q <= (free_q & ~alloc_mask) | rel_mask;
        end else begin
            free_q <= free_q | rel_mask;
        end
    end

endmodule

// File: rtl/rfd_maptable.sv
module rfd_maptable
    import rfd_pkg::*;
#(
    parameter int L = LANES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     grant,
    input  ren_req_t ren  [L],
    input  preg_t    pick [L],
    output preg_t    prev [L],
    input  cmt_req_t cmt  [L],
    output pmask_t   rel_mask,
    output pmask_t   cmt_used_nxt
);

    preg_t spec_q [ARCH_N];
    preg_t cmt_q  [ARCH_N];
    preg_t spec_n [ARCH_N];
    preg_t cmt_n  [ARCH_N];

    always_comb begin
        spec_n = spec_q;
        for (int i = 0; i < L; i++) begin
            prev[i] = spec_n[ren[i].areg];
            if (ren[i].vld) spec_n[ren[i].areg] = pick[i];
        end
    end

    always_comb begin
        cmt_n    = cmt_q;
        rel_mask = '0;
        for (int i = 0; i < L; i++) begin
            if (cmt[i].vld) begin
                rel_mask[cmt_n[cmt[i].areg]] = 1'b1;
                cmt_n[cmt[i].areg] = cmt[i].preg;
            end
        end
        cmt_used_nxt = '0;
        for (int a = 0; a < ARCH_N; a++) cmt_used_nxt[cmt_n[a]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < ARCH_N; a++) begin
                spec_q[a] <= preg_t'(a);
                cmt_q[a]  <= preg_t'(a);
            end
        end else begin
            cmt_q <= cmt_n;
            if (flush) spec_q <= cmt_n;
            else if (grant) spec_q <= spec_n;
        end
    end

endmodule

// File: rtl/dup_regfile.sv
module dup_regfile
    import rfd_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [WR_PORTS-1:0]       wr_vld,
    input  logic [WR_PORTS*PW-1:0]    wr_idx,
    input  logic [WR_PORTS*XLEN-1:0]  wr_data,
    input  logic [EX_RD*PW-1:0]       ex_raddr,
    output logic [EX_RD*XLEN-1:0]     ex_rdata,
    input  logic [LS_RD*PW-1:0]       ls_raddr,
    output logic [LS_RD*XLEN-1:0]     ls_rdata,
    input  logic [LANES-1:0]          ren_vld,
    input  logic [LANES*AW-1:0]       ren_areg,
    output logic                      ren_ok,
    output logic [LANES*PW-1:0]       ren_preg,
    output logic [LANES*PW-1:0]       ren_prev,
    input  logic [LANES-1:0]          cmt_vld,
    input  logic [LANES*AW-1:0]       cmt_areg,
    input  logic [LANES*PW-1:0]       cmt_preg,
    input  logic                      flush
);

    wr_req_t  wr_bus  [WR_PORTS];
    preg_t    ex_addr [EX_RD];
    word_t    ex_word [EX_RD];
    preg_t    ls_addr [LS_RD];
    word_t    ls_word [LS_RD];
    ren_req_t ren_bus [LANES];
    cmt_req_t cmt_bus [LANES];
    preg_t    pick    [LANES];
    preg_t    prev    [LANES];
    pmask_t   rel_mask;
    pmask_t   cmt_used_nxt;
    logic     grant;

    for (genvar p = 0; p < WR_PORTS; p++) begin : g_wr
        assign wr_bus[p] = '{vld:  wr_vld[p],
                             idx:  wr_idx[p*PW +: PW],
                             data: wr_data[p*XLEN +: XLEN]};
    end

    for (genvar r = 0; r < EX_RD; r++) begin : g_ex
        assign ex_addr[r] = ex_raddr[r*PW +: PW];
        assign ex_rdata[r*XLEN +: XLEN] = ex_word[r];
    end

    for (genvar r = 0; r < LS_RD; r++) begin : g_ls
        assign ls_addr[r] = ls_raddr[r*PW +: PW];
        assign ls_rdata[r*XLEN +: XLEN] = ls_word[r];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign ren_bus[i] = '{vld: ren_vld[i], areg: ren_areg[i*AW +: AW]};
        assign cmt_bus[i] = '{vld:  cmt_vld[i],
                              areg: cmt_areg[i*AW +: AW],
                              preg: cmt_preg[i*PW +: PW]};
        assign ren_preg[i*PW +: PW] = pick[i];
        assign ren_prev[i*PW +: PW] = prev[i];
    end

    assign grant = ren_ok & ~flush;

    rfd_bank #(.NR(EX_RD)) u_ex_copy (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_bus),
        .raddr (ex_addr),
        .rdata (ex_word)
    );

    rfd_bank #(.NR(LS_RD)) u_ls_copy (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_bus),
        .raddr (ls_addr),
        .rdata (ls_word)
    );

    rfd_freelist #(.L(LANES)) u_pool (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .grant        (grant),
        .req          (ren_vld),
        .rel_mask     (rel_mask),
        .cmt_used_nxt (cmt_used_nxt),
        .ok           (ren_ok),
        .pick         (pick)
    );

    rfd_maptable #(.L(LANES)) u_maps (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .grant        (grant),
        .ren          (ren_bus),
        .pick         (pick),
        .prev         (prev),
        .cmt          (cmt_bus),
        .rel_mask     (rel_mask),
        .cmt_used_nxt (cmt_used_nxt)
    );

endmodule

// File: rtl/rfd_chk.sv
module rfd_chk
    import rfd_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   flush,
    input logic [EX_RD*PW-1:0]    ex_raddr,
    input logic [EX_RD*XLEN-1:0]  ex_rdata,
    input logic [LS_RD*PW-1:0]    ls_raddr,
    input logic [LS_RD*XLEN-1:0]  ls_rdata,
    input logic [LANES-1:0]       ren_vld,
    input logic                   ren_ok,
    input logic [LANES*PW-1:0]    ren_preg
);

    // R2
    copies_agree_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_raddr[PW-1:0] == ls_raddr[PW-1:0]) |->
        (ex_rdata[XLEN-1:0] == ls_rdata[XLEN-1:0]));

    // R2
    copies_agree_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_raddr[(EX_RD-1)*PW +: PW] == ls_raddr[(LS_RD-1)*PW +: PW]) |->
        (ex_rdata[(EX_RD-1)*XLEN +: XLEN] == ls_rdata[(LS_RD-1)*XLEN +: XLEN]));

    // R5
    distinct_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (ren_ok && ren_vld[0] && ren_vld[1]) |->
        (ren_preg[PW-1:0] != ren_preg[2*PW-1:PW]));

    // R5
    no_reissue_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush && ren_ok && ren_vld[0]) |=>
        !(ren_ok && ren_vld[0] && (ren_preg[PW-1:0] == $past(ren_preg[PW-1:0]))));

    // R8
    refill_after_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> ren_ok);

endmodule

bind dup_regfile rfd_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .ex_raddr (ex_raddr),
    .ex_rdata (ex_rdata),
    .ls_raddr (ls_raddr),
    .ls_rdata (ls_rdata),
    .ren_vld  (ren_vld),
    .ren_ok   (ren_ok),
    .ren_preg (ren_preg)
);

// File: tb/sim_dup_regfile.sv
module sim_dup_regfile;
    import rfd_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [WR_PORTS-1:0]      wr_vld;
    logic [WR_PORTS*PW-1:0]   wr_idx;
    logic [WR_PORTS*XLEN-1:0] wr_data;
    logic [EX_RD*PW-1:0]      ex_raddr;
    logic [EX_RD*XLEN-1:0]    ex_rdata;
    logic [LS_RD*PW-1:0]      ls_raddr;
    logic [LS_RD*XLEN-1:0]    ls_rdata;
    logic [LANES-1:0]         ren_vld;
    logic [LANES*AW-1:0]      ren_areg;
    logic                     ren_ok;
    logic [LANES*PW-1:0]      ren_preg;
    logic [LANES*PW-1:0]      ren_prev;
    logic [LANES-1:0]         cmt_vld;
    logic [LANES*AW-1:0]      cmt_areg;
    logic [LANES*PW-1:0]      cmt_preg;
    logic                     flush;

    dup_regfile u0 (.*);

    int n_chk = 0;
    int n_bad = 0;

    logic [XLEN-1:0] mrf [PHYS_N];
    int  mspec [ARCH_N];
    int  mcmt  [ARCH_N];
    bit  mfree [PHYS_N];
    int  qa [$];
    int  qp [$];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R1-watchdog: actual timeout expected completion");
        finish_run();
    end

    function automatic logic [63:0] exp_read(input int idx);
        logic [63:0] w;
        w = mrf[idx];
        for (int p = 0; p < WR_PORTS; p++)
            if (wr_vld[p] && int'(wr_idx[p*PW +: PW]) == idx) w = wr_data[p*XLEN +: XLEN];
        return w;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < PHYS_N; k++) begin
            mrf[k]   = '0;
            mfree[k] = (k >= ARCH_N);
        end
        for (int a = 0; a < ARCH_N; a++) begin
            mspec[a] = a;
            mcmt[a]  = a;
        end
        qa.delete();
        qp.delete();
    endtask

    task automatic clear_in();
        wr_vld = '0; wr_idx = '0; wr_data = '0;
        ex_raddr = '0; ls_raddr = '0;
        ren_vld = '0; ren_areg = '0;
        cmt_vld = '0; cmt_areg = '0; cmt_preg = '0;
        flush = 1'b0;
    endtask

    task automatic set_ren(input int i, input int a);
        ren_vld[i] = 1'b1;
        ren_areg[i*AW +: AW] = AW'(a);
    endtask

    task automatic set_cmts(input int k);
        for (int i = 0; i < k; i++) begin
            if (qa.size() > 0) begin
                cmt_vld[i] = 1'b1;
                cmt_areg[i*AW +: AW] = AW'(qa.pop_front());
                cmt_preg[i*PW +: PW] = PW'(qp.pop_front());
            end
        end
    endtask

    task automatic set_reads(input int a);
        for (int r = 0; r < EX_RD; r++) ex_raddr[r*PW +: PW] = PW'(a);
        for (int r = 0; r < LS_RD; r++) ls_raddr[r*PW +: PW] = PW'(a);
    endtask

    task automatic set_write(input int p, input int idx, input logic [63:0] d);
        wr_vld[p] = 1'b1;
        wr_idx[p*PW +: PW] = PW'(idx);
        wr_data[p*XLEN +: XLEN] = d;
    endtask

    // Inputs are set after a falling edge; outputs sampled 1 unit later,
    // model advanced just after the rising edge.
    task automatic run_cycle(input string tag);
        bit tmpf [PHYS_N];
        int tspec [ARCH_N];
        int pick [LANES];
        int prv [LANES];
        int cnt, need, a, old;
        bit ok;
        #1;
        for (int r = 0; r < EX_RD; r++)
            chk(tag, "ex read", ex_rdata[r*XLEN +: XLEN], exp_read(int'(ex_raddr[r*PW +: PW])));
        for (int r = 0; r < LS_RD; r++)
            chk(tag, "ls read", ls_rdata[r*XLEN +: XLEN], exp_read(int'(ls_raddr[r*PW +: PW])));
        cnt = 0;
        need = 0;
        for (int k = 0; k < PHYS_N; k++) begin
            tmpf[k] = mfree[k];
            if (mfree[k]) cnt++;
        end
        for (int i = 0; i < LANES; i++) if (ren_vld[i]) need++;
        ok = (cnt >= need);
        for (int x = 0; x < ARCH_N; x++) tspec[x] = mspec[x];
        for (int i = 0; i < LANES; i++) begin
            pick[i] = 0;
            a = int'(ren_areg[i*AW +: AW]);
            prv[i] = tspec[a];
            if (ren_vld[i]) begin
                for (int k = PHYS_N - 1; k >= 0; k--) if (tmpf[k]) pick[i] = k;
                tmpf[pick[i]] = 1'b0;
                tspec[a] = pick[i];
            end
        end
        if (need > 0) begin
            chk(tag, "ren_ok", 64'(ren_ok), 64'(ok));
            if (ok) begin
                for (int i = 0; i < LANES; i++) begin
                    if (ren_vld[i]) begin
                        chk(tag, "ren_preg", 64'(ren_preg[i*PW +: PW]), 64'(pick[i]));
                        chk(tag, "ren_prev", 64'(ren_prev[i*PW +: PW]), 64'(prv[i]));
                    end
                end
            end
        end
        @(posedge clk);
        #1;
        for (int p = 0; p < WR_PORTS; p++)
            if (wr_vld[p]) mrf[int'(wr_idx[p*PW +: PW])] = wr_data[p*XLEN +: XLEN];
        for (int i = 0; i < LANES; i++) begin
            if (cmt_vld[i]) begin
                a = int'(cmt_areg[i*AW +: AW]);
                old = mcmt[a];
                mfree[old] = 1'b1;
                mcmt[a] = int'(cmt_preg[i*PW +: PW]);
            end
        end
        if (flush) begin
            for (int k = 0; k < PHYS_N; k++) mfree[k] = 1'b1;
            for (int x = 0; x < ARCH_N; x++) begin
                mfree[mcmt[x]] = 1'b0;
                mspec[x] = mcmt[x];
            end
            qa.delete();
            qp.delete();
        end else if (ok) begin
            for (int i = 0; i < LANES; i++) begin
                if (ren_vld[i]) begin
                    a = int'(ren_areg[i*AW +: AW]);
                    mfree[pick[i]] = 1'b0;
                    mspec[a] = pick[i];
                    qa.push_back(a);
                    qp.push_back(pick[i]);
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic rand_cycle(input bit traffic);
        clear_in();
        for (int p = 0; p < WR_PORTS; p++)
            if ($urandom % 2 == 0) set_write(p, int'($urandom % PHYS_N), {$urandom, $urandom});
        for (int r = 0; r < EX_RD; r++)
            ex_raddr[r*PW +: PW] = ($urandom % 4 == 0 && wr_vld[0]) ? wr_idx[PW-1:0]
                                                                    : PW'($urandom % PHYS_N);
        for (int r = 0; r < LS_RD; r++)
            ls_raddr[r*PW +: PW] = ($urandom % 4 == 0 && wr_vld[1]) ? wr_idx[2*PW-1:PW]
                                                                    : PW'($urandom % PHYS_N);
        if (traffic) begin
            for (int i = 0; i < LANES; i++)
                if ($urandom % 2 == 0) set_ren(i, int'($urandom % ARCH_N));
            set_cmts(int'($urandom % 5));
            flush = ($urandom % 40 == 0);
            run_cycle("R5/R6/R7/R8");
        end else begin
            run_cycle("R2/R3/R4");
        end
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < PHYS_N; a++) begin
            clear_in();
            set_reads(a);
            #1;
            for (int r = 0; r < LS_RD; r++)
                chk(tag, "copy match", ls_rdata[r*XLEN +: XLEN], ex_rdata[r*XLEN +: XLEN]);
            run_cycle(tag);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        clear_in();
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        // R1: reads during reset are zero
        @(negedge clk);
        #1;
        chk("R1", "read in reset", ex_rdata[XLEN-1:0], 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1: all entries zero after reset, on both copies
        sweep("R1");

        // R1 / R6: reset map identity, pool starts at 32, same-group forwarding
        clear_in();
        set_ren(0, 5); set_ren(1, 5); set_ren(2, 7); set_ren(3, 0);
        run_cycle("R1/R6");

        // R5: drain the pool, then a request is refused with nothing taken
        for (int c = 0; c < 3; c++) begin
            clear_in();
            for (int i = 0; i < LANES; i++) set_ren(i, 12 + 4 * c + i);
            run_cycle("R5");
        end
        clear_in(); set_ren(0, 1); run_cycle("R5");
        clear_in(); set_ren(2, 1); run_cycle("R5");

        // R8: flush refills the pool and restores the map; rename ignored
        clear_in(); flush = 1'b1; set_ren(0, 9); run_cycle("R8");
        clear_in();
        for (int i = 0; i < LANES; i++) set_ren(i, 8 + i);
        run_cycle("R8");

        // R6: two lanes rename the same register
        clear_in(); set_ren(0, 3); set_ren(1, 3); run_cycle("R6");

        // R7: commit four, then two to the same register in one group
        clear_in(); set_cmts(4); run_cycle("R7");
        clear_in(); set_cmts(2); run_cycle("R7");
        clear_in();
        for (int i = 0; i < LANES; i++) set_ren(i, 20 + i);
        run_cycle("R7");

        // R8: commit in the flush cycle is kept, in-flight renames dropped
        clear_in(); set_cmts(4); set_ren(0, 1); run_cycle("R7");
        clear_in(); set_cmts(1); flush = 1'b1; set_ren(0, 2); run_cycle("R8");
        clear_in(); set_ren(0, 1); set_ren(1, 2); run_cycle("R8");

        // R3: read of the entry being written
        clear_in(); set_write(2, 9, 64'hdead_beef_0123_4567); set_reads(9); run_cycle("R3");
        // R4: all ports write the same entry
        clear_in();
        for (int p = 0; p < WR_PORTS; p++) set_write(p, 7, 64'h1111_0000_0000_0000 * (p + 1));
        set_reads(7);
        run_cycle("R4");
        clear_in(); set_reads(7); run_cycle("R4");
        clear_in(); set_reads(9); run_cycle("R2");

        for (int c = 0; c < 2000; c++) rand_cycle(1'b0);
        sweep("R2");
        for (int c = 0; c < 3000; c++) rand_cycle(1'b1);
        sweep("R2");

        finish_run();
    end

endmodule